// File: doc/BRIEF.md
# Multi-lane transmit phase alignment sequencer

This block is a control state machine that runs on a free-running management clock. It performs manual transmit phase and delay alignment for four serial transceiver lanes that share a single alignment process. A start request from one designated master lane launches the sequence. The block then walks every lane through four steps in order: delay soft reset, phase initialisation, phase alignment, and delay enable on the master lane. After each step it waits for the lanes to report that the step is complete.

The lane status flags come from clock domains other than the management clock. Each one passes through a two-flop synchroniser before the block uses it, and so does the start request. The sequence counts as finished on the second rising edge of the master lane's phase-align-done flag, counted from the moment all lanes have left delay soft reset. At that point the block raises one shared done flag that every lane consumes. The done flag stays high until the next start request.

A new start request at any step aborts the current run and begins again at delay soft reset. The same restart happens when a step stays incomplete for a programmable number of cycles.

Top module: `txalign_seq`

## Requirements
- R1: While reset is active and after it is released, all four strobe vectors and the done output are low until a start request arrives.
- R2: A rising edge of the synchronised start input asserts delay soft reset on all lanes, sets every other strobe to 0 and clears done.
- R3: Delay soft reset is held on all lanes until all four reset-done inputs are high. Then phase init is asserted on all lanes and delay soft reset drops.
- R4: Phase init is held until all four init-done inputs are high. Then phase align is asserted on all lanes and phase init drops.
- R5: Phase align is held until all four align-done inputs are high. Then delay enable is asserted only on the master lane bit (bit MASTER, default 0) and phase align drops.
- R6: Done rises only on the second rising edge of the master lane's align-done input, counted since the sequence left delay soft reset. A falling edge does not count. All strobes are 0 while done is high.
- R7: Done stays high, whatever the status inputs do and even if start falls, until the next start rising edge.
- R8: A start rising edge at any step, including a later step or the done state, aborts the run: done goes low and delay soft reset is asserted on all lanes again.
- R9: If a step receives no completion for TIMEOUT_CYC consecutive cycles, the sequence restarts at delay soft reset.
- R10: Every status and start input is synchronised through two flops. A change applied between clock edges has no visible effect for two rising edges and is reflected in the outputs after the third.
- R11: At most one of the groups delay reset, phase init, phase align, delay enable and done is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running management clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start/restart request from the master lane (asynchronous) |
| rst_done | input | LANES | Per-lane delay soft reset complete |
| init_done | input | LANES | Per-lane phase init complete |
| align_done | input | LANES | Per-lane phase align complete |
| dly_rst | output | LANES | Per-lane delay soft reset |
| ph_init | output | LANES | Per-lane phase init |
| ph_align | output | LANES | Per-lane phase align |
| dly_en | output | LANES | Per-lane delay alignment enable (manual mode) |
| seq_done | output | 1 | Shared alignment-complete flag |

## Verification
The hardest situation to reach is the delay-enable step with the edge count part-way through. This happens when the master lane's align-done has already produced its first rising edge, possibly before the other lanes finished aligning, and the bench must show that a falling edge alone does not finish the run. The bench drops and raises the master flag inside the delay-enable step and checks done both before and after the second rise. It also abandons runs in late steps and withholds completions, so that the abort and timeout restarts are observed from the strobes.

// File: rtl/txalign_seq.sv
module txalign_seq #(
  parameter int LANES       = 4,
  parameter int MASTER      = 0,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [LANES-1:0] rst_done,
  input  logic [LANES-1:0] init_done,
  input  logic [LANES-1:0] align_done,
  output logic [LANES-1:0] dly_rst,
  output logic [LANES-1:0] ph_init,
  output logic [LANES-1:0] ph_align,
  output logic [LANES-1:0] dly_en,
  output logic             seq_done
);
  localparam int TW = $clog2(TIMEOUT_CYC);
  localparam logic [LANES-1:0] MBIT = LANES'(1) << MASTER;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_INIT, S_ALIGN, S_DLYEN, S_DONE} st_t;
  st_t state, nxt;

  logic st_m, st_s, st_q;
  logic [LANES-1:0] rd_m, rd_s, id_m, id_s, ad_m, ad_s;
  logic ad_q;
  logic [TW-1:0] tcnt;
  logic [1:0] ecnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      {st_m, st_s, st_q, ad_q} <= '0;
      {rd_m, rd_s, id_m, id_s, ad_m, ad_s} <= '0;
    end else begin
      st_m <= start_req;  st_s <= st_m;  st_q <= st_s;
      rd_m <= rst_done;   rd_s <= rd_m;
      id_m <= init_done;  id_s <= id_m;
      ad_m <= align_done; ad_s <= ad_m;
      ad_q <= ad_s[MASTER];
    end
  end

  wire start_rise = st_s & ~st_q;
  wire al_rise    = ad_s[MASTER] & ~ad_q;
  wire waiting    = state inside {S_RST, S_INIT, S_ALIGN, S_DLYEN};
  wire tmo        = waiting && (tcnt == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    nxt = state;
    case (state)
      S_RST:   if (&rd_s) nxt = S_INIT;
      S_INIT:  if (&id_s) nxt = S_ALIGN;
      S_ALIGN: if (&ad_s) nxt = S_DLYEN;
      S_DLYEN: if (ecnt == 2'd2 || (al_rise && ecnt == 2'd1)) nxt = S_DONE;
      default: nxt = state;
    endcase
    if (tmo)        nxt = S_RST;
    if (start_rise) nxt = S_RST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      tcnt  <= '0;
      ecnt  <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || tmo || start_rise || !waiting) tcnt <= '0;
      else tcnt <= tcnt + 1'b1;
      if (state == S_RST || start_rise) ecnt <= '0;
      else if (al_rise && ecnt != 2'd2) ecnt <= ecnt + 1'b1;
    end
  end

  assign dly_rst  = {LANES{state == S_RST}};
  assign ph_init  = {LANES{state == S_INIT}};
  assign ph_align = {LANES{state == S_ALIGN}};
  assign dly_en   = (state == S_DLYEN) ? MBIT : '0;
  assign seq_done = (state == S_DONE);

  // R11
  one_group_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|dly_rst, |ph_init, |ph_align, |dly_en, seq_done}));

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_rise |=> (&dly_rst) && !seq_done);

  // R3
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RST) && !(&rd_s) && !tmo |=> (&dly_rst));

  // R5
  dlyen_master_chk: assert property (@(posedge clk) disable iff (rst)
    (|dly_en) |-> (dly_en == MBIT));

  // R6
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done) |-> $past(ad_s[MASTER]));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done && !start_rise |=> seq_done);

  // R9
  timeout_chk: assert property (@(posedge clk) disable iff (rst)
    tmo && !start_rise |=> (&dly_rst));
endmodule

// File: tb/tb_txalign_seq.sv
module tb_txalign_seq;
  localparam int CLK_P  = 10;
  localparam int LANES  = 4;
  localparam int MASTER = 0;
  localparam int TMO    = 64;

  logic clk = 0, rst = 1, start_req = 0;
  logic [LANES-1:0] rst_done = '0, init_done = '0, align_done = '0;
  logic [LANES-1:0] dly_rst, ph_init, ph_align, dly_en;
  logic seq_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  txalign_seq #(.LANES(LANES), .MASTER(MASTER), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .rst_done(rst_done),
    .init_done(init_done), .align_done(align_done), .dly_rst(dly_rst),
    .ph_init(ph_init), .ph_align(ph_align), .dly_en(dly_en), .seq_done(seq_done));

  // step: 0 idle, 1 delay reset, 2 init, 3 align, 4 delay enable, 5 done
  function automatic logic [16:0] exp_vec(int step);
    case (step)
      1: return 17'h0000F;
      2: return 17'h000F0;
      3: return 17'h00F00;
      4: return 17'(1 << MASTER) << 12;
      5: return 17'h10000;
      default: return '0;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int step);
    logic [16:0] act;
    act = {seq_done, dly_en, ph_align, ph_init, dly_rst};
    checks++;
    if (act !== exp_vec(step)) begin
      errors++;
      $display("FAIL %s: outputs %h expected %h", req, act, exp_vec(step));
    end
  endtask

  task automatic set_bit(int which, int lane, logic v);
    case (which)
      0: rst_done[lane] = v;
      1: init_done[lane] = v;
      default: align_done[lane] = v;
    endcase
  endtask

  task automatic raise_lanes(int which, int cur_step, string req);
    int base;
    base = $urandom % LANES;
    for (int i = 0; i < LANES; i++) begin
      set_bit(which, (base + i) % LANES, 1'b1);
      if (i == LANES - 2) begin
        tick(5);
        chk(req, cur_step);
      end else if (i < LANES - 1) tick($urandom_range(1, 6));
    end
  endtask

  task automatic begin_run();
    start_req = 0; rst_done = '0; init_done = '0; align_done = '0;
    tick(4);
    start_req = 1;
    tick(4);
  endtask

  task automatic restart(string req);
    start_req = 0; rst_done = '0; init_done = '0; align_done = '0;
    tick(4);
    start_req = 1;
    tick(4);
    chk(req, 1);
  endtask

  task automatic run_to_dlyen(bit first);
    begin_run();
    chk("R2", 1);
    raise_lanes(0, 1, "R3");
    if (first) begin
      tick(2);
      chk("R10", 1);
      tick(2);
    end else tick(4);
    chk("R3", 2);
    raise_lanes(1, 2, "R4");
    tick(4);
    chk("R4", 3);
    raise_lanes(2, 3, "R5");
    tick(4);
    chk("R5", 4);
  endtask

  initial begin
    process::self().srandom(32'd7719);
    tick(3);
    chk("R1", 0);
    rst = 0;
    tick(6);
    chk("R1", 0);
    rst_done = '1; align_done = '1;
    tick(6);
    chk("R1", 0);

    for (int r = 0; r < 4; r++) begin
      run_to_dlyen(r == 0);
      align_done[MASTER] = 0;
      tick($urandom_range(5, 9));
      chk("R6", 4);
      align_done[MASTER] = 1;
      tick(4);
      chk("R6", 5);
      for (int k = 0; k < 3; k++) begin
        align_done[MASTER] = ~align_done[MASTER];
        rst_done = 4'($urandom);
        tick($urandom_range(3, 12));
      end
      start_req = 0;
      tick($urandom_range(10, 40));
      chk("R7", 5);
    end

    run_to_dlyen(0);
    restart("R8");
    raise_lanes(0, 1, "R3");
    tick(4);
    chk("R3", 2);
    restart("R8");
    begin_run();
    chk("R2", 1);

    begin_run();
    raise_lanes(0, 1, "R3");
    tick(4);
    chk("R9", 2);
    rst_done = '0;
    tick(30);
    chk("R9", 2);
    tick(45);
    chk("R9", 1);

    run_to_dlyen(0);
    rst_done = '0; init_done = '0; align_done = '0;
    tick(30);
    chk("R9", 4);
    tick(45);
    chk("R9", 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule